// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit resolves the operand of one instruction. It takes a 4-bit mode code, an address-or-constant field, a register index, the current program counter and an operand size. It works out the effective address, fetches the operand from data memory when the mode needs it, and returns the address and the operand together with a one-cycle completion strobe. It holds a small register file for base, index and pointer values, and a side port loads that register file. In the auto-increment and auto-decrement modes the unit writes the stepped pointer back into the register file itself.

Requests enter through a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and every request field stable until that edge. A request presented while the unit is busy is back-pressured and is not lost. Memory is a plain request port: `mem_rdata` carries the word for the address presented on `mem_addr` in the cycle after `mem_req` was high. The unit makes zero, one or two memory references, depending on the mode.

Top module: `addr_mode_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `done`, `mem_req` and `illegal` are 0. Every register in the register file reads as 0.
- R2: Mode 0 (immediate) returns `req_field` as the operand and 0 as the address. It makes no memory request, and `done` is high in the cycle after acceptance. `done` always lasts exactly one cycle.
- R3: Mode 3 (register) returns the selected register as the operand and 0 as the address. It makes no memory request, and `done` is high in the cycle after acceptance.
- R4: Mode 1 (direct) makes one memory request at `req_field` and returns `req_field` as the address. The returned word is the operand, and `done` is high in the third cycle after acceptance.
- R5: Mode 2 (indirect) makes two requests. The first goes to `req_field`. The second goes to the word the first one returned. That word is the reported address, and `done` is high in the fifth cycle after acceptance.
- R6: Mode 4 (register-indirect) uses the selected register as the address and makes one memory request.
- R7: Mode 5 (indexed) uses register plus field as the address. Mode 6 (relative) uses `req_pc` plus field. Both sums wrap modulo 2^XLEN, and both modes make one memory request.
- R8: Mode 7 (auto-increment) uses the register's old value as the address. It adds the operand size to the register when the data word returns.
- R9: Mode 8 (auto-decrement) subtracts the operand size from the register on the acceptance edge. It then uses the new value as the address.
- R10: `req_size` encodes the step in bytes: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R11: Codes 9 to 15 set `illegal` and report 0 as both address and operand. They make no memory request and leave every register unchanged, and `done` is high in the cycle after acceptance. The next legal request clears `illegal`.
- R12: `req_ready` is low from the acceptance edge until the cycle after `done`. A request held valid during that time is accepted only once the unit is idle again.
- R13: The side port writes `rf_wdata` into register `rf_waddr` on the edge where `rf_we` is high. If an auto-mode update hits the same register on the same edge, the update wins. A side write to a different register on that edge still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 4 | Addressing mode code |
| req_field | input | XLEN | Address or constant field |
| req_reg | input | log2(NREGS) | Register index |
| req_pc | input | XLEN | Program counter of the instruction |
| req_size | input | 2 | Operand size code |
| rf_we | input | 1 | Side write enable for the register file |
| rf_waddr | input | log2(NREGS) | Side write register index |
| rf_wdata | input | XLEN | Side write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | XLEN | Memory read address |
| mem_rdata | input | XLEN | Read data, valid the cycle after the request |
| done | output | 1 | One-cycle strobe: address and operand are valid |
| illegal | output | 1 | Last request had an undefined mode |
| ea | output | XLEN | Effective address |
| operand | output | XLEN | Operand value |

## Verification
The auto-mode pointer update and a side-port register write can land on the same register on the same clock edge. The bench provokes this in two places. For auto-decrement it drives the side write in the acceptance cycle. For auto-increment it drives the side write in the cycle the data word returns. In both cases it reads the register back through a register-mode request and expects the stepped pointer value, not the side-written value. A side write to a different register in the same cycle must still appear when that register is read back.

// File: rtl/amu_pkg.sv
package amu_pkg;

  localparam logic [3:0] MODE_IMM  = 4'd0;
  localparam logic [3:0] MODE_DIR  = 4'd1;
  localparam logic [3:0] MODE_IND  = 4'd2;
  localparam logic [3:0] MODE_REG  = 4'd3;
  localparam logic [3:0] MODE_RIND = 4'd4;
  localparam logic [3:0] MODE_IDX  = 4'd5;
  localparam logic [3:0] MODE_REL  = 4'd6;
  localparam logic [3:0] MODE_AINC = 4'd7;
  localparam logic [3:0] MODE_ADEC = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WT,
    ST_FIN
  } amu_state_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/amu_regfile.sv
module amu_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIW-1:0]  raddr,
  output logic [XLEN-1:0] rdata,
  input  logic            we,
  input  logic [RIW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic            upd_en,
  input  logic [RIW-1:0]  upd_idx,
  input  logic [XLEN-1:0] upd_val
);

  logic [XLEN-1:0] q [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[i] <= '0;
      end else if (upd_en && upd_idx == RIW'(i)) begin
        q[i] <= upd_val;
      end else if (we && waddr == RIW'(i)) begin
        q[i] <= wdata;
      end
    end
  end

  assign rdata = q[raddr];

  // R13
  upd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && we && waddr == upd_idx) |=> (q[$past(upd_idx)] == $past(upd_val)));

  // R13
  side_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !(upd_en && waddr == upd_idx)) |=> (q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/amu_ea_calc.sv
module amu_ea_calc #(
  parameter int XLEN = 32
) (
  input  logic [3:0]      mode,
  input  logic [XLEN-1:0] field,
  input  logic [XLEN-1:0] rval,
  input  logic [XLEN-1:0] pc,
  input  logic [1:0]      size_sel,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] imm_val,
  output logic [XLEN-1:0] step,
  output logic [1:0]      mem_refs,
  output logic            legal,
  output logic            pre_upd,
  output logic            post_upd
);
  import amu_pkg::*;

  assign step = XLEN'(size_to_bytes(size_sel));

  always_comb begin
    ea       = '0;
    imm_val  = '0;
    mem_refs = 2'd0;
    legal    = 1'b1;
    pre_upd  = 1'b0;
    post_upd = 1'b0;
    case (mode)
      MODE_IMM:  imm_val = field;
      MODE_DIR:  begin ea = field;       mem_refs = 2'd1; end
      MODE_IND:  begin ea = field;       mem_refs = 2'd2; end
      MODE_REG:  imm_val = rval;
      MODE_RIND: begin ea = rval;        mem_refs = 2'd1; end
      MODE_IDX:  begin ea = rval + field; mem_refs = 2'd1; end
      MODE_REL:  begin ea = pc + field;  mem_refs = 2'd1; end
      MODE_AINC: begin ea = rval; mem_refs = 2'd1; post_upd = 1'b1; end
      MODE_ADEC: begin ea = rval - step; mem_refs = 2'd1; pre_upd = 1'b1; end
      default:   legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl #(
  parameter int XLEN = 32,
  parameter int RIW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_mode,
  input  logic [RIW-1:0]  req_reg,
  input  logic [XLEN-1:0] c_ea,
  input  logic [XLEN-1:0] c_imm,
  input  logic [XLEN-1:0] c_step,
  input  logic [1:0]      c_refs,
  input  logic            c_legal,
  input  logic            c_pre,
  input  logic            c_post,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] operand,
  output logic            upd_en,
  output logic [RIW-1:0]  upd_idx,
  output logic [XLEN-1:0] upd_val
);
  import amu_pkg::*;

  amu_state_e      state_q;
  logic [XLEN-1:0] addr_q, ea_q, op_q, step_q;
  logic [1:0]      refs_q;
  logic            post_q, ill_q;
  logic [RIW-1:0]  idx_q;
  logic            accept, last_ret;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_ret  = (state_q == ST_WT) && (refs_q == 2'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ea_q    <= '0;
      op_q    <= '0;
      step_q  <= '0;
      refs_q  <= 2'd0;
      post_q  <= 1'b0;
      ill_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ill_q  <= !c_legal;
          idx_q  <= req_reg;
          step_q <= c_step;
          post_q <= c_post;
          if (!c_legal) begin
            ea_q    <= '0;
            op_q    <= '0;
            state_q <= ST_FIN;
          end else if (c_refs == 2'd0) begin
            ea_q    <= '0;
            op_q    <= c_imm;
            state_q <= ST_FIN;
          end else begin
            addr_q  <= c_ea;
            ea_q    <= c_ea;
            refs_q  <= c_refs;
            state_q <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_WT;
        ST_WT: begin
          if (refs_q == 2'd2) begin
            addr_q  <= mem_rdata;
            ea_q    <= mem_rdata;
            refs_q  <= 2'd1;
            state_q <= ST_RD;
          end else begin
            op_q    <= mem_rdata;
            state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    upd_en  = 1'b0;
    upd_idx = idx_q;
    upd_val = ea_q + step_q;
    if (accept && c_legal && c_pre) begin
      upd_en  = 1'b1;
      upd_idx = req_reg;
      upd_val = c_ea;
    end else if (last_ret && post_q) begin
      upd_en = 1'b1;
    end
  end

  assign mem_req  = (state_q == ST_RD);
  assign mem_addr = addr_q;
  assign done     = (state_q == ST_FIN);
  assign illegal  = ill_q;
  assign ea       = ea_q;
  assign operand  = op_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  imm_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode == MODE_IMM) |=> (done && !mem_req));

  // R4
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R5
  chain_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WT && refs_q == 2'd2) |=> (mem_req && mem_addr == $past(mem_rdata)));

  // R11
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mode > MODE_ADEC) |=> (done && illegal && !mem_req && !upd_en));

  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/addr_mode_unit.sv
module addr_mode_unit #(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  localparam int RIW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_mode,
  input  logic [XLEN-1:0] req_field,
  input  logic [RIW-1:0]  req_reg,
  input  logic [XLEN-1:0] req_pc,
  input  logic [1:0]      req_size,
  input  logic            rf_we,
  input  logic [RIW-1:0]  rf_waddr,
  input  logic [XLEN-1:0] rf_wdata,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            done,
  output logic            illegal,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] operand
);

  logic [XLEN-1:0] rval, c_ea, c_imm, c_step, upd_val;
  logic [1:0]      c_refs;
  logic            c_legal, c_pre, c_post, upd_en;
  logic [RIW-1:0]  upd_idx;

  amu_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .raddr   (req_reg),
    .rdata   (rval),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .upd_val (upd_val)
  );

  amu_ea_calc #(.XLEN(XLEN)) u_calc (
    .mode     (req_mode),
    .field    (req_field),
    .rval     (rval),
    .pc       (req_pc),
    .size_sel (req_size),
    .ea       (c_ea),
    .imm_val  (c_imm),
    .step     (c_step),
    .mem_refs (c_refs),
    .legal    (c_legal),
    .pre_upd  (c_pre),
    .post_upd (c_post)
  );

  amu_ctrl #(.XLEN(XLEN), .RIW(RIW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mode  (req_mode),
    .req_reg   (req_reg),
    .c_ea      (c_ea),
    .c_imm     (c_imm),
    .c_step    (c_step),
    .c_refs    (c_refs),
    .c_legal   (c_legal),
    .c_pre     (c_pre),
    .c_post    (c_post),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .done      (done),
    .illegal   (illegal),
    .ea        (ea),
    .operand   (operand),
    .upd_en    (upd_en),
    .upd_idx   (upd_idx),
    .upd_val   (upd_val)
  );

endmodule

// File: tb/addr_mode_unit_bench.sv
module addr_mode_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_mode = '0;
  logic [31:0] req_field = '0;
  logic [2:0]  req_reg = '0;
  logic [31:0] req_pc = '0;
  logic [1:0]  req_size = '0;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_waddr = '0;
  logic [31:0] rf_wdata = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        done, illegal;
  logic [31:0] ea, operand;

  int total = 0;
  int bad = 0;
  int nreq = 0;
  logic [31:0] hist0 = '0, hist1 = '0;

  logic [31:0] r_op, r_ea;
  logic        r_ill;
  int          r_lat, r_refs;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_mode_unit u_addr_mode_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_field(req_field), .req_reg(req_reg),
    .req_pc(req_pc), .req_size(req_size), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .done(done), .illegal(illegal), .ea(ea),
    .operand(operand)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a ^ 32'h5A5A_0000) + 32'd7;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= memf(mem_addr);
      hist1     <= hist0;
      hist0     <= mem_addr;
      nreq      <= nreq + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = idx; rf_wdata = val;
    @(negedge clk);
    rf_we = 1'b0;
  endtask

  // coll_at: negedge index (0 = acceptance cycle) at which a side write is driven; -1 none
  task automatic run_op(input logic [3:0] m, input logic [31:0] f, input logic [2:0] idx,
                        input logic [31:0] pc, input logic [1:0] sz, input int coll_at,
                        input logic [2:0] cw_idx, input logic [31:0] cw_val);
    int base;
    @(negedge clk);
    base = nreq;
    req_valid = 1'b1; req_mode = m; req_field = f; req_reg = idx; req_pc = pc; req_size = sz;
    rf_we = (coll_at == 0); rf_waddr = cw_idx; rf_wdata = cw_val;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 1;
    rf_we = (coll_at == 1);
    while (!done && r_lat < 20) begin
      @(negedge clk);
      r_lat++;
      rf_we = (coll_at == r_lat);
    end
    rf_we = 1'b0;
    r_op = operand; r_ea = ea; r_ill = illegal; r_refs = nreq - base;
    @(negedge clk);
    chk("R2 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [31:0] v);
    run_op(4'd3, 32'd0, idx, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    v = r_op;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    rd_reg(3'd5, v);
    chk("R1 reg zero", v, 32'd0);
  endtask

  task automatic t_imm;
    run_op(4'd0, 32'h1234_5678, 3'd0, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R2 operand", r_op, 32'h1234_5678);
    chk("R2 ea", r_ea, 32'd0);
    chk("R2 latency", r_lat, 1);
    chk("R2 refs", r_refs, 0);
  endtask

  task automatic t_reg;
    wr_reg(3'd2, 32'hCAFE_0001);
    run_op(4'd3, 32'hFFFF, 3'd2, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R3 operand", r_op, 32'hCAFE_0001);
    chk("R3 latency", r_lat, 1);
    chk("R3 refs", r_refs, 0);
  endtask

  task automatic t_direct;
    run_op(4'd1, 32'h100, 3'd0, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R4 ea", r_ea, 32'h100);
    chk("R4 operand", r_op, memf(32'h100));
    chk("R4 latency", r_lat, 3);
    chk("R4 refs", r_refs, 1);
    chk("R4 addr", hist0, 32'h100);
  endtask

  task automatic t_indirect;
    logic [31:0] p;
    p = memf(32'h200);
    run_op(4'd2, 32'h200, 3'd0, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R5 ea", r_ea, p);
    chk("R5 operand", r_op, memf(p));
    chk("R5 latency", r_lat, 5);
    chk("R5 refs", r_refs, 2);
    chk("R5 first addr", hist1, 32'h200);
    chk("R5 second addr", hist0, p);
  endtask

  task automatic t_rind;
    wr_reg(3'd3, 32'h4000);
    run_op(4'd4, 32'h55, 3'd3, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R6 ea", r_ea, 32'h4000);
    chk("R6 operand", r_op, memf(32'h4000));
    chk("R6 refs", r_refs, 1);
  endtask

  task automatic t_idx_rel;
    wr_reg(3'd4, 32'h1000);
    run_op(4'd5, 32'h24, 3'd4, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R7 indexed ea", r_ea, 32'h1024);
    chk("R7 indexed operand", r_op, memf(32'h1024));
    run_op(4'd6, 32'h20, 3'd0, 32'hFFFF_FFF0, 2'd0, -1, 3'd0, 32'd0);
    chk("R7 relative wrap ea", r_ea, 32'h10);
    chk("R7 relative refs", r_refs, 1);
  endtask

  task automatic t_ainc;
    logic [31:0] v;
    wr_reg(3'd5, 32'h800);
    run_op(4'd7, 32'd0, 3'd5, 32'd0, 2'd1, -1, 3'd0, 32'd0);
    chk("R8 ea old value", r_ea, 32'h800);
    chk("R8 operand", r_op, memf(32'h800));
    rd_reg(3'd5, v);
    chk("R8 R10 step two", v, 32'h802);
    run_op(4'd7, 32'd0, 3'd5, 32'd0, 2'd0, -1, 3'd0, 32'd0);
    chk("R8 ea second", r_ea, 32'h802);
    rd_reg(3'd5, v);
    chk("R10 step one", v, 32'h803);
  endtask

  task automatic t_adec;
    logic [31:0] v;
    wr_reg(3'd6, 32'h900);
    run_op(4'd8, 32'd0, 3'd6, 32'd0, 2'd2, -1, 3'd0, 32'd0);
    chk("R9 ea new value", r_ea, 32'h8FC);
    chk("R9 operand", r_op, memf(32'h8FC));
    rd_reg(3'd6, v);
    chk("R9 R10 reg after", v, 32'h8FC);
    run_op(4'd8, 32'd0, 3'd6, 32'd0, 2'd3, -1, 3'd0, 32'd0);
    chk("R10 code three", r_ea, 32'h8F8);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    run_op(4'd9, 32'h77, 3'd5, 32'd0, 2'd2, -1, 3'd0, 32'd0);
    chk("R11 flag", {31'd0, r_ill}, 32'd1);
    chk("R11 operand", r_op, 32'd0);
    chk("R11 ea", r_ea, 32'd0);
    chk("R11 latency", r_lat, 1);
    chk("R11 refs", r_refs, 0);
    run_op(4'd15, 32'h77, 3'd5, 32'd0, 2'd2, -1, 3'd0, 32'd0);
    chk("R11 code 15", {31'd0, r_ill}, 32'd1);
    rd_reg(3'd5, v);
    chk("R11 reg untouched", v, 32'h803);
    chk("R11 flag cleared", {31'd0, r_ill}, 32'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    req_valid = 1'b1; req_mode = 4'd0; req_field = 32'hAAAA_0001;
    @(negedge clk);
    chk("R12 done first", {31'd0, done}, 32'd1);
    chk("R12 busy not ready", {31'd0, req_ready}, 32'd0);
    req_field = 32'hBBBB_0002;
    @(negedge clk);
    chk("R12 ready again", {31'd0, req_ready}, 32'd1);
    chk("R12 no early done", {31'd0, done}, 32'd0);
    chk("R12 held operand", operand, 32'hAAAA_0001);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 second done", {31'd0, done}, 32'd1);
    chk("R12 second operand", operand, 32'hBBBB_0002);
    @(negedge clk);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr_reg(3'd7, 32'h500);
    run_op(4'd8, 32'd0, 3'd7, 32'd0, 2'd2, 0, 3'd7, 32'h1111);
    rd_reg(3'd7, v);
    chk("R13 adec wins", v, 32'h4FC);
    wr_reg(3'd1, 32'h300);
    run_op(4'd7, 32'd0, 3'd1, 32'd0, 2'd2, 2, 3'd1, 32'h2222);
    rd_reg(3'd1, v);
    chk("R13 ainc wins", v, 32'h304);
    run_op(4'd8, 32'd0, 3'd7, 32'd0, 2'd0, 0, 3'd2, 32'h3333);
    rd_reg(3'd2, v);
    chk("R13 other reg written", v, 32'h3333);
    rd_reg(3'd7, v);
    chk("R13 pointer stepped", v, 32'h4FB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm();
    t_reg();
    t_direct();
    t_indirect();
    t_rind();
    t_idx_rel();
    t_ainc();
    t_adec();
    t_illegal();
    t_backpressure();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule